// File: doc/BRIEF.md
# Selectable Divided Clock Enable Generator

This block makes two clock-enable strobes for a system that runs on one main clock. No derived clock is produced and no clock is gated. A register that would nominally run on a slower clock stays on the main clock and advances only in the cycles where its enable strobe is high.

The auxiliary strobe counts rising edges of an asynchronous low-frequency reference. The sub-main strobe counts either every main-clock cycle or those same reference edges, chosen by a select bit. Each strobe has its own power-of-two divider.

Software programs the block through an 8-bit register port with byte offsets. A write takes effect at the clock edge where the write strobe is high. Read data depends only on the address and the stored fields; there is no read strobe.

Top module: `ckenGen`

## Requirements
- R1: While reset is high, and on the first sampled edge after reset was sampled high, both enables are low. Reset clears every field, which gives divide-by-1 and the fast source for both strobes.
- R2: The register at byte offset 0x06 keeps the auxiliary divider code in bits [5:4]. Its other bits read as 0, so writing 0xFF reads back 0x30.
- R3: The register at byte offset 0x08 keeps the sub-main source select in bit 3 (0 = main clock, 1 = slow reference) and the sub-main divider code in bits [2:1]. Its other bits read as 0, so writing 0xFF reads back 0x0E.
- R4: Offset 0x04, and every other offset that is not mapped, reads as 0x00. A write to such an offset changes no field and does not restart either counter.
- R5: Divider code c divides by 2^c (codes 0 to 3 give 1, 2, 4 and 8). The auxiliary enable pulses once for every 2^c rising edges of the slow reference.
- R6: With the fast source selected, the sub-main enable pulses once every 2^c main-clock cycles. With code 0 it stays high continuously.
- R7: With the slow source selected, the sub-main enable pulses once for every 2^c rising edges of the slow reference.
- R8: The slow reference passes through a two-flop synchronizer, and only its rising edges count. Take a rising edge first sampled at clock edge k. At division by 1, the enable is high for the one cycle that follows edge k+2. Falling edges, and a level held high, add no further pulses.
- R9: A write to a divider register (0x06 or 0x08) restarts that register's counter from zero, even when the written value equals the stored one. After the restart, the first pulse comes after exactly 2^c base ticks.
- R10: Apart from the fast source at divide-by-1, each pulse lasts exactly one main-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Asynchronous reset, active high |
| regAddr | input | AddrW | Register byte offset |
| regWr | input | 1 | Write strobe for the addressed register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| slowRef | input | 1 | Asynchronous low-frequency reference |
| auxEn | output | 1 | Auxiliary clock-enable strobe |
| subEn | output | 1 | Sub-main clock-enable strobe |

## Verification
The bench targets the points where an off-by-one in the synchronizer or the divider is easy to make:

- **Edge latency.** A design with one flop too few or too many puts every pulse a cycle early or late.
- **Edge detection.** A design that detects levels instead of edges fires repeatedly while the reference is held high.
- **Divider period.** A counter compared against the wrong limit gives periods of 2^c+1 or 2^(c-1).
- **Restart on rewrite.** A design that restarts only when the value changes lets the old phase run through.
- **Readback masking.** A design that returns the raw write byte on unused bits reads back nonzero.
- **Unmapped writes.** A design that decodes offset 0x04 loosely corrupts a real field.

// File: rtl/ckenPkg.sv
package ckenPkg;
  localparam int CodeW = 2;

  typedef struct packed {
    logic [CodeW-1:0] auxDiv;
    logic             subSel;
    logic [CodeW-1:0] subDiv;
  } ckenCfg_t;

  typedef struct packed {
    logic auxRestart;
    logic subRestart;
  } ckenStrobe_t;
endpackage

// File: rtl/ckenCtrl.sv
module ckenCtrl
  import ckenPkg::*;
#(
  parameter int             AddrW  = 8,
  parameter logic [AddrW-1:0] AuxOfs = 8'h06,
  parameter logic [AddrW-1:0] SubOfs = 8'h08
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output ckenCfg_t         cfg,
  output ckenStrobe_t      strb
);
  logic wrAux;
  logic wrSub;

  assign wrAux = regWr && (regAddr == AuxOfs);
  assign wrSub = regWr && (regAddr == SubOfs);

  // A write restarts the matching counter even if the value does not change.
  assign strb.auxRestart = wrAux;
  assign strb.subRestart = wrSub;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (wrAux) cfg.auxDiv <= wrData[5:4];
      if (wrSub) begin
        cfg.subSel <= wrData[3];
        cfg.subDiv <= wrData[2:1];
      end
    end
  end

  // Unused bits and unmapped offsets read as zero.
  always_comb begin
    rdData = 8'h00;
    if (regAddr == AuxOfs) rdData = {2'b00, cfg.auxDiv, 4'b0000};
    else if (regAddr == SubOfs) rdData = {4'b0000, cfg.subSel, cfg.subDiv, 1'b0};
  end
endmodule

// File: rtl/ckenDivider.sv
module ckenDivider #(
  parameter int CodeW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CodeW-1:0] code,
  output logic             en
);
  localparam int CntW = (1 << CodeW) - 1;

  logic [CntW-1:0] cnt;
  logic [CntW-1:0] limit;
  logic            atLimit;

  // Terminal count is 2^code - 1: the low `code` bits are ones.
  always_comb begin
    for (int i = 0; i < CntW; i++) limit[i] = (i < int'(code));
  end

  assign atLimit = (cnt == limit);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt <= '0;
      en  <= 1'b0;
    end else begin
      en <= tick && atLimit;
      if (restart)   cnt <= '0;
      else if (tick) cnt <= atLimit ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ckenDatapath.sv
module ckenDatapath
  import ckenPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        slowRef,
  input  ckenCfg_t    cfg,
  input  ckenStrobe_t strb,
  output logic        auxEn,
  output logic        subEn
);
  // The synchronizer stages plus one extra flop for edge detection.
  logic [SyncStages:0] syncSh;
  logic                slowTick;
  logic                subTick;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) syncSh <= '0;
    else     syncSh <= {syncSh[SyncStages-1:0], slowRef};
  end

  assign slowTick = syncSh[SyncStages-1] & ~syncSh[SyncStages];
  assign subTick  = cfg.subSel ? slowTick : 1'b1;

  ckenDivider #(.CodeW(CodeW)) u_auxDiv (
    .clk     (clk),
    .rst     (rst),
    .restart (strb.auxRestart),
    .tick    (slowTick),
    .code    (cfg.auxDiv),
    .en      (auxEn)
  );

  ckenDivider #(.CodeW(CodeW)) u_subDiv (
    .clk     (clk),
    .rst     (rst),
    .restart (strb.subRestart),
    .tick    (subTick),
    .code    (cfg.subDiv),
    .en      (subEn)
  );
endmodule

// File: rtl/ckenGen.sv
module ckenGen
  import ckenPkg::*;
#(
  parameter int               AddrW      = 8,
  parameter int               SyncStages = 2,
  parameter logic [AddrW-1:0] AuxOfs     = 8'h06,
  parameter logic [AddrW-1:0] SubOfs     = 8'h08
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             slowRef,
  output logic             auxEn,
  output logic             subEn
);
  ckenCfg_t    cfg;
  ckenStrobe_t strb;

  ckenCtrl #(.AddrW(AddrW), .AuxOfs(AuxOfs), .SubOfs(SubOfs)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .regAddr (regAddr),
    .regWr   (regWr),
    .wrData  (wrData),
    .rdData  (rdData),
    .cfg     (cfg),
    .strb    (strb)
  );

  ckenDatapath #(.SyncStages(SyncStages)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .slowRef (slowRef),
    .cfg     (cfg),
    .strb    (strb),
    .auxEn   (auxEn),
    .subEn   (subEn)
  );
endmodule

// File: rtl/ckenGen_chk.sv
module ckenGen_chk
  import ckenPkg::*;
#(
  parameter int               AddrW   = 8,
  parameter logic [AddrW-1:0] NullOfs = 8'h04
) (
  input logic             clk,
  input logic             rst,
  input logic [AddrW-1:0] regAddr,
  input logic [7:0]       rdData,
  input logic             auxEn,
  input logic             subEn,
  input ckenCfg_t         cfg
);
  logic fastDiv1;
  assign fastDiv1 = !cfg.subSel && (cfg.subDiv == '0);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!auxEn && !subEn)); // R1

  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regAddr == NullOfs) |-> (rdData == 8'h00)); // R4

  AST_FAST_DIV1_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fastDiv1)) |-> subEn); // R6

  AST_AUX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    auxEn |=> !auxEn); // R10

  AST_SUB_SLOW_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (subEn && $past(cfg.subSel) && cfg.subSel) |=> !subEn); // R10
endmodule

bind ckenGen ckenGen_chk #(.AddrW(AddrW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .regAddr (regAddr),
  .rdData  (rdData),
  .auxEn   (auxEn),
  .subEn   (subEn),
  .cfg     (cfg)
);

// File: tb/ckenGen_bench.sv
`timescale 1ns/1ps
module ckenGen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] regAddr = 8'h00;
  logic       regWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       slowRef = 1'b0;
  logic [7:0] rdData;
  logic       auxEn, subEn;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  ckenGen u_ckenGen (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWr(regWr),
    .wrData(wrData), .rdData(rdData), .slowRef(slowRef),
    .auxEn(auxEn), .subEn(subEn)
  );

  // Behavioural reference model, advanced on every rising edge.
  int mAux = 0, mSel = 0, mSub = 0;
  int cntA = 0, cntS = 0;
  bit expA = 0, expS = 0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst) begin
      bit tick, baseA, baseS, nA, nS;
      int limA, limS;
      tick  = hist[1] && !hist[2];
      baseA = tick;
      baseS = (mSel != 0) ? tick : 1'b1;
      limA  = (1 << mAux) - 1;
      limS  = (1 << mSub) - 1;
      nA = baseA && (cntA == limA);
      nS = baseS && (cntS == limS);
      if (regWr && regAddr == 8'h06) cntA = 0;
      else if (baseA) cntA = (cntA == limA) ? 0 : cntA + 1;
      if (regWr && regAddr == 8'h08) cntS = 0;
      else if (baseS) cntS = (cntS == limS) ? 0 : cntS + 1;
      expA = nA;
      expS = nS;
      if (regWr && regAddr == 8'h06) mAux = int'(wrData[5:4]);
      if (regWr && regAddr == 8'h08) begin
        mSel = int'(wrData[3]);
        mSub = int'(wrData[2:1]);
      end
      hist.push_front(slowRef);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] expRead(logic [7:0] a);
    if (a == 8'h06) return 8'(mAux << 4);
    if (a == 8'h08) return 8'((mSel << 3) | (mSub << 1));
    return 8'h00;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output against the model on each falling edge.
  always @(negedge clk) begin
    if (!done) begin
      check("auxEn", int'(auxEn), int'(expA));
      check("subEn", int'(subEn), int'(expS));
      check("rdData", int'(rdData), int'(expRead(regAddr)));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step();
    regAddr = a; wrData = d; regWr = 1'b1;
    step();
    regWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] want);
    step();
    regAddr = a;
    step();
    check("readback", int'(rdData), int'(want));
  endtask

  // Toggle the slow reference with the given half period.
  task automatic slowRun(int half, int edges);
    for (int e = 0; e < edges; e++) begin
      slowRef = 1'b1; step(half);
      slowRef = 1'b0; step(half);
    end
  endtask

  initial begin
    step(4);
    tag = "R1";
    rd(8'h06, 8'h00);
    rd(8'h08, 8'h00);
    rst = 1'b0;
    step(2);
    tag = "R6"; step(10);
    wr(8'h08, 8'h02); step(20);
    wr(8'h08, 8'h04); step(24);
    wr(8'h08, 8'h06); step(40);
    tag = "R2"; wr(8'h06, 8'hFF); rd(8'h06, 8'h30);
    tag = "R3"; wr(8'h08, 8'hFF); rd(8'h08, 8'h0E);
    tag = "R4"; wr(8'h04, 8'hFF); rd(8'h04, 8'h00);
    rd(8'h06, 8'h30); rd(8'h08, 8'h0E); rd(8'h1F, 8'h00);
    tag = "R8"; wr(8'h06, 8'h00);
    slowRef = 1'b1; step(20); slowRef = 1'b0; step(10);
    slowRun(1, 6);
    for (int c = 0; c < 4; c++) begin
      tag = "R5"; wr(8'h06, 8'(c << 4));
      slowRun(3, 3 * (1 << c) + 1);
    end
    for (int c = 0; c < 4; c++) begin
      tag = "R7"; wr(8'h08, 8'(8'h08 | (c << 1)));
      slowRun(2, 3 * (1 << c) + 1);
    end
    tag = "R9"; wr(8'h08, 8'h04); step(5);
    wr(8'h08, 8'h04); step(12);
    wr(8'h06, 8'h10); slowRun(2, 1); wr(8'h06, 8'h10); slowRun(2, 5);
    tag = "R10"; wr(8'h08, 8'h0E); wr(8'h06, 8'h30); slowRun(1, 20);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule